// File: doc/BRIEF.md
# Dual-Channel Metering Decimation Front-End

This block turns two 1-bit delta-sigma modulator bitstreams, one carrying voltage and one carrying current, into 24-bit signed sample pairs. Both streams are sampled on a shared modulator-rate enable (one eighth of the divided master clock). Each stream passes through its own cascaded integrator-comb decimator: second order for voltage and fourth order for current. Both decimate by 128, so the two channels keep one output word rate and share one output-valid strobe.

Ahead of its decimator, the voltage stream passes through a fractional delay. This delay lets software line up the voltage phase against the current phase. The delay is a linear interpolation between the present and the previous modulator sample. A 7-bit two's-complement phase word sets it in steps of 1/128 of a modulator period, added to a fixed base of half a period.

Results are scaled so that a full-scale input gives nearly the same magnitude, about ±2^23, on both channels. They saturate at the 24-bit limits. The first two output words after reset are computed but not flagged valid.

Top module: `meter_decim_frontend`

## Requirements
- R1: While reset is asserted, both sample outputs read 0 and the valid strobe is low.
- R2: After settling, the valid strobe is high for exactly one clock per 128 modulator-rate enables. The outputs hold their value between strobes.
- R3: The first two output words after reset are suppressed. The first strobe follows the 384th enable accepted after reset.
- R4: Modulator bit 1 counts as +1 and bit 0 as −1. A periodic stream of period 16 with k ones per period yields exactly (2k−16)·2^19 on either channel, whatever the phase word.
- R5: Results beyond the 24-bit range saturate. An all-ones stream gives 8388607 and an all-zeros stream gives −8388608.
- R6: The voltage sample is the interpolation w = (128−d)·x[n] + d·x[n−1], with d = 64 + PC and PC read as a 7-bit two's-complement number. A larger PC therefore delays the voltage path more. On a rising step, the voltage output falls linearly as PC rises.
- R7: The phase word has no effect on the current channel.
- R8: The phase word is captured only at the modulator sample that completes an output word. A change made part-way through a word affects samples only from the next word onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Modulator-rate sample enable |
| v_bit | input | 1 | Voltage modulator bit |
| i_bit | input | 1 | Current modulator bit |
| phase_word | input | 7 | Two's-complement phase-compensation value |
| v_sample | output | 24 | Signed voltage sample |
| i_sample | output | 24 | Signed current sample |
| out_valid | output | 1 | One-clock strobe marking a new sample pair |

## Verification
The assertions rely on two properties of the inputs. First, the modulator enable is a single-clock pulse, so a word boundary is one clock wide. Second, the bitstreams and the phase word are known values whenever the enable is high. The bench raises the enable on alternate clocks only. It drives bits and phase word at the falling edge from fully defined patterns: periodic densities of period 16, which divides the decimation ratio so that every word is exact, and a single rising step. Phase-word changes in the stimulus land either before reset release or part-way through a word, which exercises the capture rule.

// File: rtl/meter_decim_pkg.sv
package meter_decim_pkg;
  localparam int unsigned DEC_LOG2 = 7;
  localparam int unsigned OUT_W    = 24;
  localparam int unsigned PC_W     = 7;
  localparam int unsigned V_ORDER  = 2;
  localparam int unsigned I_ORDER  = 4;
  localparam int unsigned SETTLE   = 2;
endpackage

// File: rtl/frame_timer.sv
module frame_timer #(
  parameter int unsigned LOG2_R = 7,
  parameter int unsigned SETTLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_en,
  output logic tick,
  output logic valid
);
  localparam int unsigned SC_W = $clog2(SETTLE + 1);
  localparam logic [LOG2_R-1:0] LAST = '1;

  logic [LOG2_R-1:0] cnt_q, cnt_nxt;
  logic [SC_W-1:0]   set_q, set_nxt;
  logic              val_q, val_nxt;

  always_comb begin
    tick    = samp_en && (cnt_q == LAST);
    cnt_nxt = samp_en ? cnt_q + 1'b1 : cnt_q;
    set_nxt = (tick && (set_q < SC_W'(SETTLE))) ? set_q + 1'b1 : set_q;
    val_nxt = tick && (set_q == SC_W'(SETTLE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      set_q <= '0;
      val_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      set_q <= set_nxt;
      val_q <= val_nxt;
    end
  end

  assign valid = val_q;

  // R2: strobes are at least one word apart
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    val_q |=> !val_q);
  // R3: a strobe only follows an enable that closed a word
  a_r3_strobe_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    val_q |-> ($past(samp_en) && ($past(cnt_q) == LAST)));
endmodule

// File: rtl/phase_interp.sv
module phase_interp #(
  parameter int unsigned PC_W = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   samp_en,
  input  logic                   frame_tick,
  input  logic                   bit_in,
  input  logic [PC_W-1:0]        pc_in,
  output logic signed [PC_W+1:0] w_out
);
  localparam logic [PC_W:0] FULL = (PC_W+1)'(1) << PC_W;
  localparam logic signed [PC_W+1:0] W_MAX = (PC_W+2)'(FULL);

  logic [PC_W-1:0] d_q, d_nxt;
  logic            prev_q, prev_nxt;
  logic [PC_W:0]   wa, wb;
  logic signed [PC_W+1:0] ta, tb;

  always_comb begin
    // offset binary: d = 64 + pc
    d_nxt    = frame_tick ? {~pc_in[PC_W-1], pc_in[PC_W-2:0]} : d_q;
    prev_nxt = samp_en ? bit_in : prev_q;
    wa = FULL - {1'b0, d_q};
    wb = {1'b0, d_q};
    ta = bit_in ? $signed({1'b0, wa}) : -$signed({1'b0, wa});
    tb = prev_q ? $signed({1'b0, wb}) : -$signed({1'b0, wb});
    w_out = ta + tb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q    <= '0;
      prev_q <= 1'b0;
    end else begin
      d_q    <= d_nxt;
      prev_q <= prev_nxt;
    end
  end

  // R8: delay setting moves only at a word boundary
  a_r8_pc_held: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(d_q));
  // R6: interpolated sample never exceeds one full-scale step
  a_r6_weight_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (w_out <= W_MAX) && (w_out >= -W_MAX));
endmodule

// File: rtl/cic_decim.sv
module cic_decim #(
  parameter int unsigned ORDER  = 2,
  parameter int unsigned IN_W   = 2,
  parameter int unsigned LOG2_R = 7,
  parameter int unsigned OUT_W  = 24,
  parameter int          SHIFT  = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    samp_en,
  input  logic                    dump_en,
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam int unsigned ACC_W = ORDER * LOG2_R + IN_W + 1;
  localparam int unsigned SW    = ACC_W + ((SHIFT > 0) ? SHIFT : 0);
  localparam logic signed [SW-1:0] MAXV = SW'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);

  logic signed [ACC_W-1:0] integ_q [ORDER];
  logic signed [ACC_W-1:0] integ_n [ORDER];
  logic signed [ACC_W-1:0] dly_q   [ORDER];
  logic signed [ACC_W-1:0] dly_n   [ORDER];
  logic signed [ACC_W-1:0] cin     [ORDER+1];
  logic signed [SW-1:0]    scl;
  logic signed [OUT_W-1:0] sat, dout_q, dout_n;

  assign integ_n[0] = samp_en ? integ_q[0] + {{(ACC_W-IN_W){din[IN_W-1]}}, din}
                              : integ_q[0];
  assign cin[0] = integ_q[ORDER-1];

  for (genvar k = 1; k < ORDER; k++) begin : g_int
    assign integ_n[k] = samp_en ? integ_q[k] + integ_q[k-1] : integ_q[k];
  end

  for (genvar k = 0; k < ORDER; k++) begin : g_comb
    assign cin[k+1] = cin[k] - dly_q[k];
    assign dly_n[k] = dump_en ? cin[k] : dly_q[k];
  end

  if (SHIFT >= 0) begin : g_up
    assign scl = SW'(cin[ORDER]) <<< SHIFT;
  end else begin : g_dn
    assign scl = cin[ORDER] >>> (-SHIFT);
  end

  always_comb begin
    if (scl > MAXV)      sat = MAXV[OUT_W-1:0];
    else if (scl < MINV) sat = MINV[OUT_W-1:0];
    else                 sat = scl[OUT_W-1:0];
    dout_n = dump_en ? sat : dout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < ORDER; k++) begin
        integ_q[k] <= '0;
        dly_q[k]   <= '0;
      end
      dout_q <= '0;
    end else begin
      for (int k = 0; k < ORDER; k++) begin
        integ_q[k] <= integ_n[k];
        dly_q[k]   <= dly_n[k];
      end
      dout_q <= dout_n;
    end
  end

  assign dout = dout_q;

  // R2: output word holds between word boundaries
  a_r2_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    !dump_en |=> $stable(dout_q));
endmodule

// File: rtl/meter_decim_frontend.sv
module meter_decim_frontend
  import meter_decim_pkg::*;
#(
  parameter int unsigned R_LOG2  = DEC_LOG2,
  parameter int unsigned O_W     = OUT_W,
  parameter int unsigned P_W     = PC_W,
  parameter int unsigned VORD    = V_ORDER,
  parameter int unsigned IORD    = I_ORDER,
  parameter int unsigned N_SETTLE = SETTLE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mod_en,
  input  logic                  v_bit,
  input  logic                  i_bit,
  input  logic [P_W-1:0]        phase_word,
  output logic signed [O_W-1:0] v_sample,
  output logic signed [O_W-1:0] i_sample,
  output logic                  out_valid
);
  localparam int V_SH = int'(O_W) - 1 - int'(VORD * R_LOG2 + P_W);
  localparam int I_SH = int'(O_W) - 1 - int'(IORD * R_LOG2);

  logic                  tick;
  logic signed [P_W+1:0] v_w;
  logic signed [1:0]     i_w;

  assign i_w = i_bit ? 2'sb01 : 2'sb11;

  frame_timer #(.LOG2_R(R_LOG2), .SETTLE(N_SETTLE)) u_timer (
    .clk(clk), .rst_n(rst_n), .samp_en(mod_en), .tick(tick), .valid(out_valid));

  phase_interp #(.PC_W(P_W)) u_interp (
    .clk(clk), .rst_n(rst_n), .samp_en(mod_en), .frame_tick(tick),
    .bit_in(v_bit), .pc_in(phase_word), .w_out(v_w));

  cic_decim #(.ORDER(VORD), .IN_W(P_W + 2), .LOG2_R(R_LOG2), .OUT_W(O_W),
              .SHIFT(V_SH)) u_vcic (
    .clk(clk), .rst_n(rst_n), .samp_en(mod_en), .dump_en(tick),
    .din(v_w), .dout(v_sample));

  cic_decim #(.ORDER(IORD), .IN_W(2), .LOG2_R(R_LOG2), .OUT_W(O_W),
              .SHIFT(I_SH)) u_icic (
    .clk(clk), .rst_n(rst_n), .samp_en(mod_en), .dump_en(tick),
    .din(i_w), .dout(i_sample));

  // R2: a fresh pair is announced only right after a word boundary
  a_r2_strobe_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(tick));
endmodule

// File: tb/tb_meter_decim_frontend.sv
module tb_meter_decim_frontend;
  logic clk = 1'b0;
  logic rst_n, mod_en, v_bit, i_bit;
  logic [6:0] phase_word;
  logic signed [23:0] v_sample, i_sample;
  logic out_valid;

  int tests = 0, fails = 0;
  int first_pulse, gap, last_pulse, pulse;
  longint cap_v, cap_i;

  always #10 clk = ~clk;

  meter_decim_frontend dut (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .v_bit(v_bit), .i_bit(i_bit),
    .phase_word(phase_word), .v_sample(v_sample), .i_sample(i_sample),
    .out_valid(out_valid));

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic gen(input int mode, input int k, input int n);
    if (mode == 0) return ((n % 16) < k);
    return (n >= 704);
  endfunction

  task automatic run_case(input int mode, input int kv, input int ki,
                          input int pa, input int pb, input int psw,
                          input int want, input bit chk_rst);
    int words = 0;
    bit ph = 1'b0;
    rst_n = 1'b0; mod_en = 1'b0; v_bit = 1'b0; i_bit = 1'b0;
    phase_word = 7'(pa);
    repeat (3) @(negedge clk);
    if (chk_rst) begin
      chk("R1 v_sample in reset", v_sample, 0);
      chk("R1 i_sample in reset", i_sample, 0);
      chk("R1 out_valid in reset", out_valid, 0);
    end
    rst_n = 1'b1;
    pulse = 0;
    while (words < want) begin
      @(negedge clk);
      if (out_valid) begin
        words++;
        if (words == 1) first_pulse = pulse;
        else gap = pulse - last_pulse;
        last_pulse = pulse;
        if (words == want) begin
          cap_v = v_sample;
          cap_i = i_sample;
        end
      end
      if (ph) begin
        mod_en = 1'b1;
        v_bit = gen(mode, kv, pulse);
        i_bit = gen(mode, ki, pulse);
        phase_word = 7'((pulse >= psw) ? pb : pa);
        pulse++;
      end else begin
        mod_en = 1'b0;
      end
      ph = !ph;
    end
    mod_en = 1'b0;
  endtask

  function automatic longint dens_exp(input int k);
    if (k == 16) return 64'd8388607;
    return longint'(2 * k - 16) * 524288;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    longint vs[4], is_[4];
    // density sweep, phase word varied to show independence (R4, R5)
    for (int k = 0; k <= 16; k++) begin
      run_case(0, k, 16 - k, k * 8 - 64, k * 8 - 64, 0, 5, k == 0);
      if (k == 0) begin
        chk("R3 first strobe after 384 enables", first_pulse, 384);
        chk("R2 strobe spacing 128 enables", gap, 128);
      end
      if (k == 0 || k == 16) begin
        chk("R5 voltage saturation", cap_v, dens_exp(k));
        chk("R5 current saturation", cap_i, dens_exp(16 - k));
      end else begin
        chk("R4 voltage density", cap_v, dens_exp(k));
        chk("R4 current density", cap_i, dens_exp(16 - k));
      end
    end
    // step response versus phase word (R6, R7)
    for (int j = 0; j < 4; j++) begin
      run_case(1, 0, 0, j * 32 - 64, j * 32 - 64, 0, 5, 1'b0);
      vs[j] = cap_v;
      is_[j] = cap_i;
      chk("R2 strobe spacing in step run", gap, 128);
    end
    chk("R6 more delay lowers step output", (vs[0] > vs[1]) ? 1 : 0, 1);
    chk("R6 linear in phase word a", vs[0] - vs[1], vs[1] - vs[2]);
    chk("R6 linear in phase word b", vs[1] - vs[2], vs[2] - vs[3]);
    chk("R6 step straddles word", ((vs[3] > -8388608) && (vs[0] < 8388607)) ? 1 : 0, 1);
    for (int j = 1; j < 4; j++) chk("R7 current unaffected by phase word", is_[j], is_[0]);
    // mid-word change must not touch the word in progress (R8)
    run_case(1, 0, 0, -64, 32, 700, 5, 1'b0);
    chk("R8 mid-word phase change deferred", cap_v, vs[0]);
    chk("R8 current unchanged", cap_i, is_[0]);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule